// File: doc/BRIEF.md
# Banked Stack Pointer and Privilege Controller

This block holds the execution state of a small processor core: whether it runs application code (thread mode) or an exception handler (handler mode), and whether the running code is privileged. It keeps two stack pointers in separate registers, a main pointer and a process pointer. It presents the pointer that the current mode and control bits select, and it uses that pointer for every stack push and pop.

The core sends strobes for exception entry, exception return and supervisor calls. It also sends a two-bit control write and push or pop requests. For a push or a pop, the block drives the memory strobe, address and data in the same cycle. Pointer, mode and control updates take effect at the next clock edge. A control write from unprivileged code is dropped, and the block reports it on a one-cycle fault flag.

Top module: `dual_stack_ctl`

## Requirements
- R1: After reset the block is in thread mode and privileged, and the main pointer is selected. The main pointer holds `sp_reset_val` with its two low bits cleared, and the process pointer holds zero.
- R2: A pulse on `exc_entry` or `svc_req` puts the block in handler mode from the next cycle. While in handler mode, `priv_o` is 1 and `psp_sel_o` is 0, whatever the control bits hold.
- R3: `exc_return` in handler mode returns to thread mode on the next cycle. `exc_return` in thread mode has no effect. When entry and return arrive in the same cycle, entry wins.
- R4: In thread mode, control bit 0 set to 1 makes execution unprivileged (`priv_o` = 0). Control bit 1 set to 1 selects the process pointer (`psp_sel_o` = 1).
- R5: A `ctrl_wr` made while `priv_o` is 1 loads `ctrl_wdata` into the control bits at the next edge. A `ctrl_wr` made while `priv_o` is 0 leaves the control bits unchanged and drives `ctrl_fault` high for exactly the next cycle.
- R6: A push drives `mem_we`, `mem_addr` = active pointer − 4 and `mem_wdata` = `push_data` in the same cycle. The active pointer equals that address from the next cycle.
- R7: A pop drives `mem_re` and `mem_addr` = active pointer in the same cycle. The active pointer is 4 higher from the next cycle.
- R8: When push and pop are requested together, only the push is performed. `mem_we` and `mem_re` are never high together.
- R9: A push or pop changes only the active pointer. The other pointer keeps its value across mode and selection changes, and pointer arithmetic wraps modulo 2^AW.
- R10: Both pointers always have their two low bits at zero.
- R11: Exception entry while already in handler mode leaves the block in handler mode. A single return then goes back to thread mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_reset_val | input | AW | Main pointer value loaded at reset |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| svc_req | input | 1 | Supervisor-call strobe |
| ctrl_wr | input | 1 | Control write request |
| ctrl_wdata | input | 2 | Control value: bit 0 = unprivileged, bit 1 = process pointer |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| push_data | input | DW | Item to push |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | AW | Stack memory address |
| mem_wdata | output | DW | Stack memory write data |
| priv_o | output | 1 | Current execution is privileged |
| handler_o | output | 1 | Handler mode active |
| psp_sel_o | output | 1 | Process pointer selected |
| sp_o | output | AW | Active stack pointer |
| ctrl_fault | output | 1 | One-cycle flag for a dropped control write |

## Verification
A corrupted mode or control register is visible on `priv_o`, `handler_o` and `psp_sel_o` in the cycle after the update that went wrong. A wrong pointer is visible on `sp_o` one cycle after the operation, and on `mem_addr` at the next push or pop. A fault on the pointer that is not selected stays hidden until the selection switches. For that reason the bench switches back to each bank after working on the other. A privilege check that goes the wrong way shows in the next cycle, either as a fault with no cause or as a control write that takes effect when it should not.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic {MODE_THREAD = 1'b0, MODE_HANDLER = 1'b1} exec_mode_e;

  // bit 1: process pointer selected in thread mode, bit 0: unprivileged thread
  typedef struct packed {
    logic use_psp;
    logic unpriv;
  } ctrl_bits_t;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;
endpackage

// File: rtl/dsc_mode_ctl.sv
module dsc_mode_ctl
  import dsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_entry,
  input  logic       exc_return,
  input  logic       svc_req,
  input  logic       ctrl_wr,
  input  ctrl_bits_t ctrl_wdata,
  output exec_mode_e mode_q,
  output ctrl_bits_t ctrl_q,
  output logic       priv,
  output logic       use_psp,
  output logic       ctrl_fault,
  output logic       sel_change
);

  function automatic logic is_priv(exec_mode_e m, ctrl_bits_t c);
    return (m == MODE_HANDLER) || !c.unpriv;
  endfunction

  function automatic logic pick_psp(exec_mode_e m, ctrl_bits_t c);
    return (m == MODE_THREAD) && c.use_psp;
  endfunction

  logic       enter_evt;
  logic       leave_evt;
  logic       wr_ok;
  logic       wr_bad;
  exec_mode_e mode_d;
  ctrl_bits_t ctrl_d;

  always_comb begin
    enter_evt  = exc_entry || svc_req;
    leave_evt  = exc_return && (mode_q == MODE_HANDLER) && !enter_evt;
    priv       = is_priv(mode_q, ctrl_q);
    use_psp    = pick_psp(mode_q, ctrl_q);
    wr_ok      = ctrl_wr && priv;
    wr_bad     = ctrl_wr && !priv;
    mode_d     = enter_evt ? MODE_HANDLER : (leave_evt ? MODE_THREAD : mode_q);
    ctrl_d     = wr_ok ? ctrl_wdata : ctrl_q;
    sel_change = pick_psp(mode_d, ctrl_d) != use_psp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_THREAD;
      ctrl_q     <= '0;
      ctrl_fault <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      ctrl_q     <= ctrl_d;
      ctrl_fault <= wr_bad;
    end
  end

endmodule

// File: rtl/dsc_stack_port.sv
module dsc_stack_port
  import dsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  input  logic [AW-1:0] active_sp,
  output logic          do_push,
  output logic          do_pop,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  function automatic logic [AW-1:0] pre_dec(logic [AW-1:0] p);
    return p - STEP;
  endfunction

  always_comb begin
    do_push   = push;
    do_pop    = pop && !push;
    mem_we    = do_push;
    mem_re    = do_pop;
    mem_addr  = do_push ? pre_dec(active_sp) : active_sp;
    mem_wdata = push_data;
  end

endmodule

// File: rtl/dsc_sp_bank.sv
module dsc_sp_bank
  import dsc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rst_msp,
  input  logic          use_psp,
  input  logic          do_push,
  input  logic          do_pop,
  output logic [AW-1:0] active_sp
);

  localparam int unsigned  BANKS = 2;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  function automatic logic [AW-1:0] word_align(logic [AW-1:0] p);
    return {p[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] step_sp(logic [AW-1:0] p, logic dn, logic up);
    if (dn)      return p - STEP;
    else if (up) return p + STEP;
    else         return p;
  endfunction

  logic [AW-1:0] sp_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (g == 1) ? use_psp : !use_psp;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp_q[g] <= (g == 0) ? word_align(rst_msp) : '0;
      else if (hit) sp_q[g] <= word_align(step_sp(sp_q[g], do_push, do_pop));
    end
  end

  assign active_sp = use_psp ? sp_q[1] : sp_q[0];

endmodule

// File: rtl/dual_stack_ctl.sv
module dual_stack_ctl
  import dsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sp_reset_val,
  input  logic          exc_entry,
  input  logic          exc_return,
  input  logic          svc_req,
  input  logic          ctrl_wr,
  input  logic [1:0]    ctrl_wdata,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          priv_o,
  output logic          handler_o,
  output logic          psp_sel_o,
  output logic [AW-1:0] sp_o,
  output logic          ctrl_fault
);

  exec_mode_e    mode_q;
  ctrl_bits_t    ctrl_q;
  logic          use_psp;
  logic          sel_change;
  logic          do_push;
  logic          do_pop;
  logic [AW-1:0] active_sp;

  dsc_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_entry  (exc_entry),
    .exc_return (exc_return),
    .svc_req    (svc_req),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_bits_t'(ctrl_wdata)),
    .mode_q     (mode_q),
    .ctrl_q     (ctrl_q),
    .priv       (priv_o),
    .use_psp    (use_psp),
    .ctrl_fault (ctrl_fault),
    .sel_change (sel_change)
  );

  dsc_stack_port #(.AW(AW), .DW(DW)) u_port (
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .active_sp (active_sp),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  dsc_sp_bank #(.AW(AW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_msp   (sp_reset_val),
    .use_psp   (use_psp),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .active_sp (active_sp)
  );

  assign handler_o = (mode_q == MODE_HANDLER);
  assign psp_sel_o = use_psp;
  assign sp_o      = active_sp;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_entry,
  input logic          exc_return,
  input logic          svc_req,
  input logic          ctrl_wr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          priv_o,
  input logic          handler_o,
  input logic          psp_sel_o,
  input logic [AW-1:0] sp_o,
  input logic          ctrl_fault,
  input logic          sel_change,
  input logic [1:0]    ctrl_q
);

  // R2
  handler_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_o |-> (priv_o && !psp_sel_o));

  // R2
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry || svc_req) |=> handler_o);

  // R3
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_o && exc_return && !exc_entry && !svc_req) |=> !handler_o);

  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_fault |-> $past(ctrl_wr && !priv_o));

  // R5
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !priv_o) |=> (ctrl_q == $past(ctrl_q)));

  // R6
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !sel_change) |=> (sp_o == $past(mem_addr)));

  // R7
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !sel_change) |=> (sp_o == $past(sp_o) + AW'(4)));

  // R8
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R10
  aligned_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o[1:0] == 2'b00);

endmodule

bind dual_stack_ctl dsc_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_entry  (exc_entry),
  .exc_return (exc_return),
  .svc_req    (svc_req),
  .ctrl_wr    (ctrl_wr),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_addr   (mem_addr),
  .priv_o     (priv_o),
  .handler_o  (handler_o),
  .psp_sel_o  (psp_sel_o),
  .sp_o       (sp_o),
  .ctrl_fault (ctrl_fault),
  .sel_change (sel_change),
  .ctrl_q     (ctrl_q)
);

// File: tb/sim_dual_stack_ctl.sv
module sim_dual_stack_ctl;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam time PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] sp_reset_val = 32'h2000_1003;
  logic          exc_entry = 0, exc_return = 0, svc_req = 0, ctrl_wr = 0;
  logic [1:0]    ctrl_wdata = 2'b00;
  logic          push = 0, pop = 0;
  logic [DW-1:0] push_data = '0;
  logic          mem_we, mem_re, priv_o, handler_o, psp_sel_o, ctrl_fault;
  logic [AW-1:0] mem_addr, sp_o;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_stack_ctl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sp_reset_val(sp_reset_val),
    .exc_entry(exc_entry), .exc_return(exc_return), .svc_req(svc_req),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .push(push), .pop(pop),
    .push_data(push_data), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .priv_o(priv_o),
    .handler_o(handler_o), .psp_sel_o(psp_sel_o), .sp_o(sp_o),
    .ctrl_fault(ctrl_fault)
  );

  // bench model of the architectural state
  bit            m_hdl = 0;
  bit            m_unpriv = 0;
  bit            m_usepsp = 0;
  logic [AW-1:0] m_msp = 32'h2000_1000;
  logic [AW-1:0] m_psp = '0;

  typedef struct {
    string         tag;
    bit            priv, hdl, psel, fault;
    logic [AW-1:0] sp;
  } exp_t;

  exp_t sb[$];

  function automatic bit m_priv();
    return m_hdl || !m_unpriv;
  endfunction
  function automatic bit m_psel();
    return !m_hdl && m_usepsp;
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, check same-cycle memory outputs, queue next-cycle state
  task automatic step(input bit ent, ret, svc, cw, input logic [1:0] cwd,
                      input bit pu, po, input logic [DW-1:0] pd, input string tag);
    logic [AW-1:0] asp;
    exp_t e;
    @(negedge clk);
    exc_entry = ent; exc_return = ret; svc_req = svc; ctrl_wr = cw;
    ctrl_wdata = cwd; push = pu; pop = po; push_data = pd;
    #1;
    asp = m_psel() ? m_psp : m_msp;
    chk(tag, "mem_we", AW'(mem_we), AW'(pu));
    chk(tag, "mem_re", AW'(mem_re), AW'(po && !pu));
    if (pu) begin
      chk(tag, "push addr", mem_addr, asp - 4);
      chk(tag, "push data", mem_wdata, pd);
    end else if (po) begin
      chk(tag, "pop addr", mem_addr, asp);
    end
    e.fault = cw && !m_priv();
    if (pu) asp = asp - 4;
    else if (po) asp = asp + 4;
    if (m_psel()) m_psp = asp; else m_msp = asp;
    if (cw && m_priv()) begin m_unpriv = cwd[0]; m_usepsp = cwd[1]; end
    if (ent || svc) m_hdl = 1;
    else if (ret) m_hdl = 0;
    e.tag = tag; e.priv = m_priv(); e.hdl = m_hdl; e.psel = m_psel();
    e.sp = m_psel() ? m_psp : m_msp;
    sb.push_back(e);
  endtask

  // monitor: compare registered outputs one tick after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "priv_o", AW'(priv_o), AW'(e.priv));
        chk(e.tag, "handler_o", AW'(handler_o), AW'(e.hdl));
        chk(e.tag, "psp_sel_o", AW'(psp_sel_o), AW'(e.psel));
        chk(e.tag, "ctrl_fault", AW'(ctrl_fault), AW'(e.fault));
        chk(e.tag, "sp_o", sp_o, e.sp);
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 and R10: reset state, reset value aligned
    chk("R1", "handler_o", AW'(handler_o), '0);
    chk("R1", "priv_o", AW'(priv_o), 1);
    chk("R1", "psp_sel_o", AW'(psp_sel_o), '0);
    chk("R10", "sp_o", sp_o, 32'h2000_1000);
    chk("R1", "ctrl_fault", AW'(ctrl_fault), '0);

    step(0,0,0,0,2'b00, 1,0, 32'hAAAA_0001, "R6");
    step(0,0,0,0,2'b00, 1,0, 32'hBBBB_0002, "R6");
    step(0,0,0,0,2'b00, 0,1, '0,            "R7");
    step(0,0,0,0,2'b00, 1,1, 32'hCCCC_0003, "R8");
    step(0,0,0,1,2'b10, 0,0, '0,            "R4_R1_psp_zero");
    step(0,0,0,0,2'b00, 1,0, 32'hDDDD_0004, "R9_wrap");
    step(0,0,0,1,2'b11, 0,0, '0,            "R4_unpriv");
    step(0,0,0,1,2'b00, 0,0, '0,            "R5_blocked");
    step(0,0,0,0,2'b00, 0,0, '0,            "R5_fault_clears");
    step(0,0,1,0,2'b00, 0,0, '0,            "R2_svc");
    step(0,0,0,0,2'b00, 1,0, 32'hEEEE_0005, "R2_R9_main_in_handler");
    step(1,0,0,0,2'b00, 0,0, '0,            "R11");
    step(0,0,0,1,2'b01, 0,0, '0,            "R5_handler_write");
    step(0,1,0,0,2'b00, 0,0, '0,            "R3_R11_return");
    step(0,1,0,0,2'b00, 0,1, '0,            "R3_ignored_R7");
    step(1,1,0,0,2'b00, 0,0, '0,            "R3_entry_wins");
    step(0,1,0,1,2'b10, 0,0, '0,            "R3_R9_psp_kept");
    step(0,0,0,0,2'b00, 0,1, '0,            "R7_psp_wrap");
    step(0,0,0,1,2'b00, 0,0, '0,            "R9_main_kept");
    step(0,0,0,0,2'b00, 0,0, '0,            "R10_idle");
    @(negedge clk);
    exc_entry = 0; exc_return = 0; svc_req = 0; ctrl_wr = 0; push = 0; pop = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule